// File: doc/BRIEF.md
# Misaligned Word Bus Sequencer

This block connects a 16-bit processor core to a byte-addressed memory made of two 8-bit banks that share one 16-bit data bus. The even bank carries even-address bytes on bus bits 7:0. The odd bank carries odd-address bytes on bus bits 15:8. The core presents one request at a time. A request has a 20-bit byte address, a byte/word size flag, a read/write flag, a core-half select and 16-bit write data. The sequencer turns each request into one or two bus cycles. For each cycle it drives the bank word address, the even-bank select `bus_a0` (active low) and the odd-bank enable `bus_bhe_n` (active low).

Bytes are carried between the core's low or high half and the bus lane of the addressed bank. A word at an even address moves in a single cycle on both lanes. A word at an odd address is split into two cycles. The first cycle moves the low byte on the high lane. The second cycle moves the high byte on the low lane, at the next byte address. Words are little-endian, and the address wraps from the top of the space back to zero. Each bus cycle lasts one clock. The core keeps `req_valid` and all request fields steady until it sees `req_ready`.

Top module: `split_bus_seq`

## Requirements
- R1: A byte access at an even address is one bus cycle with `bus_a0`=0, `bus_bhe_n`=1 and `bus_waddr` = address bits 19:1. Only the low lane (bus bits 7:0) is used.
- R2: A byte access at an odd address is one bus cycle with `bus_a0`=1, `bus_bhe_n`=0 and `bus_waddr` = address bits 19:1. Only the high lane (bus bits 15:8) is used.
- R3: A word access at an even address is one bus cycle with `bus_a0`=0 and `bus_bhe_n`=0. On a write, `bus_dout` equals `req_wdata`.
- R4: A word access at an odd address takes two bus cycles in order. The first is at `bus_waddr` = address bits 19:1 with `bus_a0`=1 and `bus_bhe_n`=0, and carries write bits 7:0 on the high lane. The second is at (address+1) bits 19:1 with `bus_a0`=0 and `bus_bhe_n`=1, and carries write bits 15:8 on the low lane.
- R5: On a byte read, the byte from the active lane appears in `rsp_rdata[7:0]` when `req_hi_sel`=0 and in `rsp_rdata[15:8]` when `req_hi_sel`=1. The other half reads as zero.
- R6: A word read returns the byte at the request address in `rsp_rdata[7:0]` and the byte at address+1 in `rsp_rdata[15:8]`, for both even and odd addresses.
- R7: On a byte write, the byte taken from the core is `req_wdata[15:8]` when `req_hi_sel`=1 and `req_wdata[7:0]` otherwise. In every single-lane write cycle, both halves of `bus_dout` carry the active byte.
- R8: `req_ready` is high for exactly one clock, in the last bus cycle of a request, and only while `bus_cyc` is high. `bus_cyc` follows `req_valid`, and `bus_we` is `req_valid` AND `req_write`.
- R9: A word access at address 0xFFFFF places its second cycle at `bus_waddr`=0 with `bus_a0`=0, so the high byte lives at address 0x00000.
- R10: After reset and whenever `req_valid` is low: `bus_cyc`=0, `bus_we`=0, `req_ready`=0, `bus_a0`=1 and `bus_bhe_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_ready | output | 1 | Pulses in the final bus cycle of a request |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hi_sel | input | 1 | Byte access: core half used (1 = bits 15:8) |
| req_wdata | input | 16 | Core write data |
| rsp_rdata | output | 16 | Assembled read data, valid with `req_ready` on reads |
| bus_waddr | output | 19 | Word address within each bank |
| bus_a0 | output | 1 | Even-bank select, active low |
| bus_bhe_n | output | 1 | Odd-bank enable, active low |
| bus_cyc | output | 1 | A bus cycle is in progress this clock |
| bus_we | output | 1 | Bus cycle is a write |
| bus_dout | output | 16 | Data toward the banks |
| bus_din | input | 16 | Data from the banks |

## Verification
Two events can coincide in one clock. The first is the close of one request's second split cycle, where the held low byte and the live lane byte combine into the read word. The second is the first bus cycle of the next request, which sees the phase register just cleared. The bench provokes this by issuing long chains of mixed requests with `req_valid` held high between them, so each new request begins in the clock right after `req_ready`. A scoreboard checks every bus cycle's address, selects and write lanes, and the cycle count and read word of every request, against an independent byte-array model. A leftover phase bit or a stale held byte shows up as a wrong select or a wrong word.

// File: rtl/split_bus_pkg.sv
package split_bus_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 2;

  typedef logic [BYTE_W-1:0] byte_t;

  // bit 0: even bank (low lane), bit 1: odd bank (high lane)
  typedef enum logic [1:0] {
    LN_NONE = 2'b00,
    LN_EVEN = 2'b01,
    LN_ODD  = 2'b10,
    LN_BOTH = 2'b11
  } lane_e;

  // which banks a bus cycle enables
  function automatic lane_e pick_lanes(logic active, logic whole, logic cyc_odd);
    if (!active) return LN_NONE;
    if (whole)   return LN_BOTH;
    return cyc_odd ? LN_ODD : LN_EVEN;
  endfunction

  // byte offered by the core for a single-lane write cycle
  function automatic byte_t core_byte(logic [LANES*BYTE_W-1:0] data,
                                      logic split, logic second, logic hi_sel);
    logic take_hi;
    take_hi = split ? second : hi_sel;
    return take_hi ? data[BYTE_W +: BYTE_W] : data[0 +: BYTE_W];
  endfunction
endpackage

// File: rtl/sbs_phase_ctl.sv
module sbs_phase_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic is_split,
  output logic ph2,
  output logic split_first,
  output logic last_cycle
);
  assign split_first = req_valid && is_split && !ph2;
  assign last_cycle  = req_valid && !split_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph2 <= 1'b0;
    else        ph2 <= split_first;
  end

  // the core keeps its request during the second split cycle
  AST_PH2_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ph2 |-> req_valid); // R8
endmodule

// File: rtl/sbs_lane_plan.sv
module sbs_lane_plan
  import split_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              ph2,
  output logic              whole,
  output logic              cyc_odd,
  output logic [ADDR_W-2:0] waddr,
  output logic              a0,
  output logic              bhe_n
);
  logic [ADDR_W-1:0] cyc_addr;
  lane_e             lanes;

  function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);   // natural wrap at the top of the space
  endfunction

  assign whole    = req_word && !req_addr[0];
  assign cyc_addr = ph2 ? step_addr(req_addr) : req_addr;
  assign cyc_odd  = cyc_addr[0];
  assign lanes    = pick_lanes(req_valid, whole, cyc_odd);
  assign waddr    = cyc_addr[ADDR_W-1:1];
  assign a0       = !lanes[0];
  assign bhe_n    = !lanes[1];

  AST_SOME_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !(a0 && bhe_n)); // R1
  AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph2 && $past(a0) && ($past(waddr) == {(ADDR_W-1){1'b1}})) |-> (waddr == '0)); // R9
endmodule

// File: rtl/sbs_wr_steer.sv
module sbs_wr_steer
  import split_bus_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_hi_sel,
  input  logic              is_split,
  input  logic              ph2,
  input  logic              whole,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned NLANE = DATA_W / BYTE_W;

  byte_t sel_byte;
  assign sel_byte = core_byte(req_wdata, is_split, ph2, req_hi_sel);

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign dout[g*BYTE_W +: BYTE_W] = whole ? req_wdata[g*BYTE_W +: BYTE_W] : sel_byte;
  end

  AST_LANE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !whole) |->
      (dout[DATA_W-1 -: BYTE_W] == dout[BYTE_W-1:0])); // R7
endmodule

// File: rtl/sbs_rd_assemble.sv
module sbs_rd_assemble
  import split_bus_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              cyc_odd,
  input  logic              whole,
  input  logic              split_first,
  input  logic              ph2,
  input  logic              req_hi_sel,
  input  logic              req_write,
  input  logic              last_cycle,
  output logic [DATA_W-1:0] rdata
);
  byte_t lane_byte;
  byte_t held_lo;

  assign lane_byte = cyc_odd ? din[DATA_W-1 -: BYTE_W] : din[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           held_lo <= '0;
    else if (split_first) held_lo <= lane_byte;
  end

  always_comb begin
    rdata = '0;
    if (last_cycle && !req_write) begin
      if (whole)           rdata = din;
      else if (ph2)        rdata = {lane_byte, held_lo};
      else if (req_hi_sel) rdata = {lane_byte, byte_t'(0)};
      else                 rdata = {byte_t'(0), lane_byte};
    end
  end

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph2) |-> (held_lo == $past(lane_byte))); // R6
endmodule

// File: rtl/split_bus_seq.sv
module split_bus_seq
  import split_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic              req_hi_sel,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-2:0] bus_waddr,
  output logic              bus_a0,
  output logic              bus_bhe_n,
  output logic              bus_cyc,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);
  logic is_split, ph2, split_first, last_cycle;
  logic whole, cyc_odd;

  assign is_split = req_word && req_addr[0];

  sbs_phase_ctl u_phase (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_split(is_split),
    .ph2(ph2), .split_first(split_first), .last_cycle(last_cycle)
  );

  sbs_lane_plan #(.ADDR_W(ADDR_W)) u_plan (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .ph2(ph2), .whole(whole), .cyc_odd(cyc_odd),
    .waddr(bus_waddr), .a0(bus_a0), .bhe_n(bus_bhe_n)
  );

  sbs_wr_steer #(.DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .req_hi_sel(req_hi_sel), .is_split(is_split),
    .ph2(ph2), .whole(whole), .dout(bus_dout)
  );

  sbs_rd_assemble #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .din(bus_din), .cyc_odd(cyc_odd), .whole(whole),
    .split_first(split_first), .ph2(ph2), .req_hi_sel(req_hi_sel),
    .req_write(req_write), .last_cycle(last_cycle), .rdata(rsp_rdata)
  );

  assign req_ready = last_cycle;
  assign bus_cyc   = req_valid;
  assign bus_we    = req_valid && req_write;

  AST_READY_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_cyc); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!req_ready && !bus_we && bus_a0 && bus_bhe_n)); // R10
  AST_SPLIT_OPENS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph2) |-> ($past(bus_a0) && !$past(bus_bhe_n) && !$past(req_ready))); // R4
  AST_SPLIT_CLOSES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ph2 |-> (!bus_a0 && bus_bhe_n && req_ready)); // R4
endmodule

// File: tb/split_bus_seq_tb_top.sv
module split_bus_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic        req_write = 1'b0;
  logic        req_hi_sel = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rsp_rdata;
  logic [18:0] bus_waddr;
  logic        bus_a0, bus_bhe_n, bus_cyc, bus_we;
  logic [15:0] bus_dout;
  logic [15:0] bus_din;

  int n_checks = 0;
  int n_fail   = 0;
  int mem_gen  = 0;

  always #10 clk = ~clk;   // 50 MHz

  split_bus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
    .req_hi_sel(req_hi_sel), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .bus_waddr(bus_waddr), .bus_a0(bus_a0), .bus_bhe_n(bus_bhe_n),
    .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_dout(bus_dout), .bus_din(bus_din)
  );

  function automatic logic [7:0] seed_byte(int a);
    return 8'((a * 37) ^ (a >> 7) ^ 8'h5C);
  endfunction

  // two-bank memory on the bus
  logic [7:0] bank_mem [int];
  function automatic logic [7:0] bank_rd(int a);
    return bank_mem.exists(a) ? bank_mem[a] : seed_byte(a);
  endfunction

  always @* begin
    int g;
    g = mem_gen;
    bus_din[7:0]  = (bus_cyc && !bus_a0)    ? bank_rd(2*int'(bus_waddr))   : 8'h5A + 8'(g & 0);
    bus_din[15:8] = (bus_cyc && !bus_bhe_n) ? bank_rd(2*int'(bus_waddr)+1) : 8'hC3;
  end

  always @(posedge clk) begin
    if (bus_cyc && bus_we) begin
      if (!bus_a0)    bank_mem[2*int'(bus_waddr)]   = bus_dout[7:0];
      if (!bus_bhe_n) bank_mem[2*int'(bus_waddr)+1] = bus_dout[15:8];
      mem_gen++;
    end
  end

  // reference model
  logic [7:0] ref_mem [int];
  function automatic logic [7:0] ref_rd(int a);
    return ref_mem.exists(a) ? ref_mem[a] : seed_byte(a);
  endfunction

  typedef struct {
    logic [18:0] waddr; logic a0; logic bhe_n; logic we; logic [15:0] dout; string tag;
  } cyc_t;
  typedef struct {
    int ncyc; logic rd; logic [15:0] rdata; string tag;
  } done_t;

  cyc_t  cyc_q [$];
  done_t done_q [$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: enter and leave at posedge + 1
  task automatic issue(input logic [19:0] a, input logic wd, input logic wr,
                       input logic hi, input logic [15:0] wdat, input string tag);
    cyc_t c; done_t d;
    logic [7:0] b;
    int n;
    int a2;
    a2 = int'((a + 20'd1) & 20'hFFFFF);
    c.we = wr; c.tag = tag;
    if (wd && a[0]) begin
      c.waddr = a[19:1]; c.a0 = 1'b1; c.bhe_n = 1'b0; c.dout = {wdat[7:0], wdat[7:0]};
      cyc_q.push_back(c);
      c.waddr = 19'(a2 >> 1); c.a0 = 1'b0; c.bhe_n = 1'b1; c.dout = {wdat[15:8], wdat[15:8]};
      cyc_q.push_back(c);
      n = 2;
    end else if (wd) begin
      c.waddr = a[19:1]; c.a0 = 1'b0; c.bhe_n = 1'b0; c.dout = wdat;
      cyc_q.push_back(c); n = 1;
    end else begin
      b = hi ? wdat[15:8] : wdat[7:0];
      c.waddr = a[19:1]; c.a0 = a[0]; c.bhe_n = !a[0]; c.dout = {b, b};
      cyc_q.push_back(c); n = 1;
    end
    d.ncyc = n; d.rd = !wr; d.tag = tag; d.rdata = '0;
    if (wr) begin
      if (wd) begin ref_mem[int'(a)] = wdat[7:0]; ref_mem[a2] = wdat[15:8]; end
      else ref_mem[int'(a)] = hi ? wdat[15:8] : wdat[7:0];
    end else begin
      if (wd) d.rdata = {ref_rd(a2), ref_rd(int'(a))};
      else    d.rdata = hi ? {ref_rd(int'(a)), 8'h00} : {8'h00, ref_rd(int'(a))};
    end
    done_q.push_back(d);
    req_valid = 1'b1; req_addr = a; req_word = wd; req_write = wr;
    req_hi_sel = hi; req_wdata = wdat;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic go_idle(int k);
    req_valid = 1'b0; req_write = 1'b0;
    repeat (k) @(posedge clk);
    #1;
  endtask

  // monitor
  int cyc_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!req_valid) begin
        chk(!bus_cyc && !bus_we && !req_ready && bus_a0 && bus_bhe_n,
            "R10", "idle bus", {bus_cyc, bus_we, req_ready, bus_a0, bus_bhe_n}, 5'b00011);
      end
      if (bus_cyc) begin
        cyc_t c;
        cyc_cnt++;
        if (cyc_q.size() == 0) chk(1'b0, "R8", "unexpected bus cycle", 1, 0);
        else begin
          c = cyc_q.pop_front();
          chk(bus_waddr == c.waddr, c.tag, "waddr", bus_waddr, c.waddr);
          chk({bus_a0, bus_bhe_n} == {c.a0, c.bhe_n}, c.tag, "a0/bhe_n",
              {bus_a0, bus_bhe_n}, {c.a0, c.bhe_n});
          chk(bus_we == c.we, "R8", "bus_we", bus_we, c.we);
          if (c.we) chk(bus_dout == c.dout, c.tag, "bus_dout", bus_dout, c.dout);
        end
      end
      if (req_ready) begin
        done_t d;
        if (done_q.size() == 0) chk(1'b0, "R8", "unexpected ready", 1, 0);
        else begin
          d = done_q.pop_front();
          chk(cyc_cnt == d.ncyc, "R8", "cycles per request", cyc_cnt, d.ncyc);
          if (d.rd) chk(rsp_rdata == d.rdata, d.tag, "rsp_rdata", rsp_rdata, d.rdata);
        end
        cyc_cnt = 0;
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!req_ready && !bus_cyc && bus_a0 && bus_bhe_n, "R10", "reset state",
        {req_ready, bus_cyc, bus_a0, bus_bhe_n}, 4'b0011);
    rst_n = 1'b1;
    go_idle(2);

    issue(20'h00010, 0, 1, 0, 16'h12AB, "R1"); go_idle(1);   // R7 low half source
    issue(20'h00011, 0, 1, 1, 16'hCD34, "R2"); go_idle(1);   // R7 high half source
    issue(20'h00010, 1, 0, 0, 16'h0000, "R3"); go_idle(1);   // expects CDAB (R6)
    issue(20'h00010, 0, 0, 1, 16'h0000, "R5"); go_idle(1);
    issue(20'h00011, 0, 0, 0, 16'h0000, "R5"); go_idle(1);
    issue(20'h00021, 1, 1, 0, 16'hBEEF, "R4"); go_idle(1);
    issue(20'h00021, 1, 0, 0, 16'h0000, "R6"); go_idle(1);
    issue(20'h00020, 1, 0, 0, 16'h0000, "R6"); go_idle(1);
    issue(20'h00022, 0, 0, 1, 16'h0000, "R6"); go_idle(1);
    issue(20'h00040, 1, 1, 0, 16'hA1B2, "R3"); go_idle(1);
    issue(20'h00041, 0, 0, 1, 16'h0000, "R2"); go_idle(1);
    issue(20'hFFFFF, 1, 1, 0, 16'h7766, "R9"); go_idle(1);
    issue(20'hFFFFF, 1, 0, 0, 16'h0000, "R9"); go_idle(1);
    issue(20'h00000, 0, 0, 0, 16'h0000, "R9"); go_idle(1);

    // back-to-back chains: split close meets next request start
    for (int i = 0; i < 40; i++) begin
      logic [19:0] a;
      a = 20'h00300 + 20'(i * 3);
      issue(a, 1, 1, 0, 16'(16'h1111 * (i % 15) + i), "R4");
      issue(a, 1, 0, 0, 16'h0000, "R6");
      issue(a + 20'd1, 0, 0, i[0], 16'h0000, "R5");
      issue(a + 20'd2, 0, 1, i[1], 16'(i * 257 + 16'h0F0F), "R7");
    end
    for (int i = 0; i < 24; i++) begin
      issue(20'h00300 + 20'(i), 1, 0, 0, 16'h0000, "R6");
    end
    go_idle(3);

    chk(cyc_q.size() == 0 && done_q.size() == 0, "R8", "scoreboard drained",
        cyc_q.size() + done_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule